// File: doc/BRIEF.md
# Transmitter Power-Mode Controller

This block steps a low-power radio transmitter through its operating modes. After power-up it waits a power-on delay and, when the non-volatile configuration has been programmed, asks an external copier to load that configuration into the registers. It then rests in deep sleep. A rising data pin or a falling clock pin wakes the synthesizer. After a fixed settling delay the power amplifier is switched on. When the data pin goes low the transmitter drops to standby. A programmable auto-off timer then returns it to deep sleep, unless the off-delay code selects "stay powered".

The same two pins also let a host take the transmitter into a serial configuration mode. It enters that mode by holding the clock pin low while the data pin stays high. It leaves again either after the serial slave reports a stop condition and the clock pin is held low once more, or after a long period with no pin activity. Both pins pass through two-flop synchronizers. Every microsecond and millisecond interval comes from a prescaler on the system clock, set by parameters.

Top module: `txpm_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the state code is 0 (power-on), and synth_en, pa_en, copy_req, cfg_mode and state_chg are all 0.
- R2: With fuse_ok high, the power-on state lasts POR_US microseconds. The block then enters state 1 (copy) and holds copy_req high. It stays there until a cycle in which copy_done is high, and enters state 2 (deep sleep) on the next cycle.
- R3: With fuse_ok low, the block goes from power-on straight to deep sleep after POR_US microseconds, and copy_req is never asserted.
- R4: In deep sleep, a rising edge on data_pin or a falling edge on clk_pin moves the block to state 3 (settling) on the third rising clock edge after the pin changes. In settling, synth_en is 1 and pa_en is 0.
- R5: Settling lasts SETTLE_US microseconds and then the block enters state 4 (transmitting). pa_en is 1 in state 4 and in no other state.
- R6: In transmitting, a low level on data_pin moves the block to state 5 (standby), where synth_en is 1 and pa_en is 0.
- R7: With off_code below 15, standby returns to deep sleep after OFF_STEP_MS × (off_code + 2) milliseconds. The tolerance is one millisecond tick.
- R8: With off_code equal to 15, standby never times out. In standby, for any off_code, a rising edge on data_pin moves the block directly to transmitting without passing through settling.
- R9: From deep sleep, settling, transmitting or standby, holding clk_pin low with data_pin high for more than CFG_HOLD_US microseconds enters state 6 (configuration). In that state cfg_mode is 1 and both enables are 0. Entry is possible only if clk_pin has been seen high since the last exit from configuration. A low clock with a low data pin never enters.
- R10: In configuration, once stop_det has pulsed, holding clk_pin low for more than CFG_HOLD_US microseconds returns the block to deep sleep. Without that pulse, a long clock-low period does not leave configuration.
- R11: In configuration, CFG_IDLE_MS milliseconds without any edge on either pin return the block to deep sleep.
- R12: state_chg is high for exactly the cycles in which state_o differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| data_pin | input | 1 | Asynchronous data / serial-data pin |
| clk_pin | input | 1 | Asynchronous clock / serial-clock pin |
| fuse_ok | input | 1 | Non-volatile configuration has been programmed |
| copy_done | input | 1 | Configuration copy finished (handshake) |
| off_code | input | OFF_CODE_W | Standby auto-off delay code; all ones means never time out |
| stop_det | input | 1 | One-cycle strobe: serial slave saw a valid stop condition |
| synth_en | output | 1 | Frequency synthesizer enable |
| pa_en | output | 1 | Power amplifier enable |
| copy_req | output | 1 | Request to copy the configuration into the registers |
| cfg_mode | output | 1 | Serial configuration mode is active |
| state_o | output | 3 | Current state code |
| state_chg | output | 1 | One-cycle pulse when the state changes |

## Verification
A pin edge reaches state_o on the third rising clock edge after it is driven: two synchronizer stages, then the state register. The bench checks one cycle before that edge and exactly at it. copy_done acts on the very next edge. Timed exits (power-on, settling, standby, configuration hold and idle) follow a free-running prescaler, so their arrival can move by up to one tick. For those exits the bench polls every cycle and accepts a window bounded by the nominal count minus and plus one tick and the synchronizer latency. Outputs are always sampled on the falling clock edge.

// File: rtl/txpm_pkg.sv
package txpm_pkg;

    typedef enum logic [2:0] {
        ST_POR    = 3'd0,
        ST_COPY   = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_TX     = 3'd4,
        ST_STBY   = 3'd5,
        ST_CFG    = 3'd6
    } pm_state_e;

endpackage

// File: rtl/txpm_sync.sv
module txpm_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end

endmodule

// File: rtl/txpm_tick.sv
module txpm_tick #(
    parameter int CYC_PER_US = 125,
    parameter int US_PER_MS  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic us_tick,
    output logic ms_tick
);

    localparam int UW = $clog2(CYC_PER_US + 1);
    localparam int MW = $clog2(US_PER_MS + 1);

    logic [UW-1:0] us_d, us_q;
    logic [MW-1:0] ms_d, ms_q;

    assign us_tick = (us_q == UW'(CYC_PER_US - 1));
    assign ms_tick = us_tick && (ms_q == MW'(US_PER_MS - 1));

    always_comb begin
        us_d = us_tick ? '0 : us_q + 1'b1;
        ms_d = ms_q;
        if (us_tick) ms_d = (ms_q == MW'(US_PER_MS - 1)) ? '0 : ms_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_q <= '0;
            ms_q <= '0;
        end else begin
            us_q <= us_d;
            ms_q <= ms_d;
        end
    end

endmodule

// File: rtl/txpm_ctrl.sv
module txpm_ctrl
    import txpm_pkg::*;
#(
    parameter int CYC_PER_US  = 125,
    parameter int US_PER_MS   = 1000,
    parameter int POR_US      = 1000,
    parameter int SETTLE_US   = 370,
    parameter int CFG_HOLD_US = 16,
    parameter int CFG_IDLE_MS = 20,
    parameter int OFF_STEP_MS = 2,
    parameter int OFF_CODE_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  data_pin,
    input  logic                  clk_pin,
    input  logic                  fuse_ok,
    input  logic                  copy_done,
    input  logic [OFF_CODE_W-1:0] off_code,
    input  logic                  stop_det,
    output logic                  synth_en,
    output logic                  pa_en,
    output logic                  copy_req,
    output logic                  cfg_mode,
    output logic [2:0]            state_o,
    output logic                  state_chg
);

    localparam int STBY_MAX_MS = OFF_STEP_MS * ((1 << OFF_CODE_W) + 1);
    localparam int MAX_A       = (POR_US > SETTLE_US) ? POR_US : SETTLE_US;
    localparam int MAX_B       = (STBY_MAX_MS > CFG_IDLE_MS) ? STBY_MAX_MS : CFG_IDLE_MS;
    localparam int TMR_MAX     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W       = $clog2(TMR_MAX + 1);
    localparam int HOLD_LIM    = CFG_HOLD_US + 1;
    localparam int HOLD_W      = $clog2(HOLD_LIM + 1);
    localparam logic [OFF_CODE_W-1:0] OFF_STAY = '1;

    typedef struct packed {
        pm_state_e         st;
        logic [TMR_W-1:0]  tmr;
        logic [HOLD_W-1:0] hold;
        logic              armed;
        logic              stop_seen;
        logic              data_p;
        logic              clk_p;
        logic              chg;
    } regs_t;

    regs_t      d, q;
    pm_state_e  nxt_st;
    logic [1:0] pin_s;
    logic       data_s, clk_s;
    logic       us_tick, ms_tick;
    logic       data_rise, data_fall, clk_rise, clk_fall;
    logic       hold_met, in_normal, tmr_tick;
    logic [TMR_W-1:0] stby_lim;

    txpm_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({clk_pin, data_pin}),
        .sync_o  (pin_s)
    );

    txpm_tick #(.CYC_PER_US(CYC_PER_US), .US_PER_MS(US_PER_MS)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .ms_tick (ms_tick)
    );

    assign data_s    = pin_s[0];
    assign clk_s     = pin_s[1];
    assign data_rise = data_s & ~q.data_p;
    assign data_fall = ~data_s & q.data_p;
    assign clk_rise  = clk_s & ~q.clk_p;
    assign clk_fall  = ~clk_s & q.clk_p;
    assign hold_met  = (q.hold == HOLD_W'(HOLD_LIM));
    assign in_normal = q.st inside {ST_SLEEP, ST_SETTLE, ST_TX, ST_STBY};
    assign tmr_tick  = (q.st == ST_STBY || q.st == ST_CFG) ? ms_tick : us_tick;
    assign stby_lim  = TMR_W'(OFF_STEP_MS) * (TMR_W'(off_code) + TMR_W'(2));

    always_comb begin
        d        = q;
        nxt_st   = q.st;
        d.data_p = data_s;
        d.clk_p  = clk_s;

        // low-hold detector: in configuration only the clock matters
        if (!(~clk_s & ((q.st == ST_CFG) | data_s))) d.hold = '0;
        else if (us_tick && !hold_met)               d.hold = q.hold + 1'b1;

        if (clk_s) d.armed = 1'b1;

        if (tmr_tick && q.tmr != '1) d.tmr = q.tmr + 1'b1;

        case (q.st)
            ST_POR: begin
                if (q.tmr == TMR_W'(POR_US)) nxt_st = fuse_ok ? ST_COPY : ST_SLEEP;
            end
            ST_COPY: begin
                if (copy_done) nxt_st = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (data_rise || clk_fall) nxt_st = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (q.tmr == TMR_W'(SETTLE_US)) nxt_st = ST_TX;
            end
            ST_TX: begin
                if (!data_s) nxt_st = ST_STBY;
            end
            ST_STBY: begin
                if (data_rise)                                  nxt_st = ST_TX;
                else if (off_code != OFF_STAY && q.tmr >= stby_lim) nxt_st = ST_SLEEP;
            end
            ST_CFG: begin
                if (stop_det) d.stop_seen = 1'b1;
                if (data_rise || data_fall || clk_rise || clk_fall) d.tmr = '0;
                if (q.stop_seen && hold_met)              nxt_st = ST_SLEEP;
                else if (q.tmr == TMR_W'(CFG_IDLE_MS))    nxt_st = ST_SLEEP;
            end
            default: nxt_st = ST_POR;
        endcase

        // configuration entry overrides every normal-mode transition
        if (in_normal && q.armed && hold_met) nxt_st = ST_CFG;

        d.chg = (nxt_st != q.st);
        d.st  = nxt_st;
        if (nxt_st != q.st) begin
            d.tmr       = '0;
            d.stop_seen = 1'b0;
            if (nxt_st == ST_CFG || q.st == ST_CFG) d.hold = '0;
            if (q.st == ST_CFG) d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign synth_en  = q.st inside {ST_SETTLE, ST_TX, ST_STBY};
    assign pa_en     = (q.st == ST_TX);
    assign copy_req  = (q.st == ST_COPY);
    assign cfg_mode  = (q.st == ST_CFG);
    assign state_o   = q.st;
    assign state_chg = q.chg;

endmodule

// File: rtl/txpm_ctrl_chk.sv
module txpm_ctrl_chk #(
    parameter int OFF_CODE_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fuse_ok,
    input logic [OFF_CODE_W-1:0] off_code,
    input logic                  synth_en,
    input logic                  pa_en,
    input logic                  copy_req,
    input logic                  cfg_mode,
    input logic [2:0]            state_o,
    input logic                  state_chg
);

    AST_PA_NEEDS_SYNTH: assert property (@(posedge clk) disable iff (!rst_n)
        pa_en |-> synth_en); // R5

    AST_PA_ONLY_TX: assert property (@(posedge clk) disable iff (!rst_n)
        pa_en |-> (state_o == 3'd4)); // R5

    AST_COPY_NEEDS_FUSE: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req |-> fuse_ok); // R3

    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |-> (!synth_en && !pa_en)); // R9

    AST_CHG_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != $past(state_o)) |-> state_chg); // R12

    AST_CHG_ONLY_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        state_chg |-> (state_o != $past(state_o))); // R12

    AST_TX_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && $past(state_o) != 3'd4)
            |-> ($past(state_o) == 3'd3 || $past(state_o) == 3'd5)); // R8

    AST_STAY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 3'd5 && state_o == 3'd2)
            |-> ($past(off_code) != '1)); // R8

endmodule

bind txpm_ctrl txpm_ctrl_chk #(.OFF_CODE_W(OFF_CODE_W)) u_chk (.*);

// File: tb/txpm_ctrl_bench.sv
module txpm_ctrl_bench;

    localparam int CPU   = 2;
    localparam int UPM   = 5;
    localparam int MS_C  = CPU * UPM;
    localparam int POR   = 20;
    localparam int SETL  = 10;
    localparam int HOLD  = 16;
    localparam int IDLE  = 20;
    localparam int STEP  = 2;
    localparam int WD    = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_pin = 1'b0;
    logic       clk_pin = 1'b1;
    logic       fuse_ok = 1'b1;
    logic       copy_done = 1'b0;
    logic [3:0] off_code = 4'd0;
    logic       stop_det = 1'b0;
    logic       synth_en, pa_en, copy_req, cfg_mode, state_chg;
    logic [2:0] state_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    bit copy_seen = 1'b0;

    always #4 clk = ~clk;

    txpm_ctrl #(
        .CYC_PER_US(CPU), .US_PER_MS(UPM), .POR_US(POR), .SETTLE_US(SETL),
        .CFG_HOLD_US(HOLD), .CFG_IDLE_MS(IDLE), .OFF_STEP_MS(STEP), .OFF_CODE_W(4)
    ) u_txpm_ctrl (
        .clk, .rst_n, .data_pin, .clk_pin, .fuse_ok, .copy_done, .off_code,
        .stop_det, .synth_en, .pa_en, .copy_req, .cfg_mode, .state_o, .state_chg
    );

    function automatic int stby_lo(int code);
        return (STEP * (code + 2) - 1) * MS_C;
    endfunction

    function automatic int stby_hi(int code);
        return STEP * (code + 2) * MS_C + 3;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_rng(string req, int act, int lo, int hi);
        nchk++;
        if (act < lo || act > hi) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_st(int exp, int maxc, output int took);
        took = -1;
        for (int i = 1; i <= maxc; i++) begin
            @(negedge clk);
            if (copy_req) copy_seen = 1'b1;
            if (state_o == 3'(exp)) begin
                took = i;
                break;
            end
        end
    endtask

    task automatic do_reset(bit fuse);
        fuse_ok   = fuse;
        data_pin  = 1'b0;
        clk_pin   = 1'b1;
        copy_done = 1'b0;
        stop_det  = 1'b0;
        rst_n     = 1'b0;
        step(3);
        rst_n     = 1'b1;
        copy_seen = 1'b0;
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int took;
        int code;
        void'($urandom(32'd2024));

        // R1 reset state
        do_reset(1'b1);
        check("R1 state", state_o, 0);
        check("R1 enables", {synth_en, pa_en, copy_req, cfg_mode, state_chg}, 0);

        // R2 power-on delay then copy handshake
        wait_st(1, 80, took);
        check_rng("R2 por delay", took, POR * CPU - 4, POR * CPU + 6);
        check("R2 copy_req", copy_req, 1);
        step(7);
        check("R2 waits for done", state_o, 1);
        copy_done = 1'b1;
        step(1);
        copy_done = 1'b0;
        check("R2 sleep after done", state_o, 2);
        check("R2 copy_req low", copy_req, 0);

        // R4 data rise wakes, latency three edges
        data_pin = 1'b1;
        step(2);
        check("R4 not yet", state_o, 2);
        step(1);
        check("R4 settle", state_o, 3);
        check("R12 pulse", state_chg, 1);
        check("R4 enables", {synth_en, pa_en}, 2'b10);
        step(1);
        check("R12 single pulse", state_chg, 0);

        // R5 settling delay then PA
        wait_st(4, 60, took);
        check_rng("R5 settle time", took, SETL * CPU - 5, SETL * CPU + 2);
        check("R5 pa_en", pa_en, 1);

        // R6 data low -> standby
        off_code = 4'd0;
        data_pin = 1'b0;
        step(3);
        check("R6 standby", state_o, 5);
        check("R6 enables", {synth_en, pa_en}, 2'b10);
        wait_st(2, 400, took);
        check_rng("R7 code 0", took, stby_lo(0), stby_hi(0));

        // R7 random off codes, random wake source
        for (int it = 0; it < 6; it++) begin
            code = $urandom_range(14, 0);
            off_code = 4'(code);
            if ($urandom_range(1, 0) == 1) begin
                clk_pin = 1'b0;
                wait_st(3, 10, took);
                check("R4 clk fall wake", took, 3);
                clk_pin = 1'b1;
                wait_st(5, 80, took);
            end else begin
                data_pin = 1'b1;
                wait_st(4, 80, took);
                step($urandom_range(20, 1));
                data_pin = 1'b0;
                wait_st(5, 10, took);
            end
            wait_st(2, 500, took);
            check_rng("R7 standby timeout", took, stby_lo(code), stby_hi(code));
        end

        // R8 code 15 stays, data rise goes straight to TX
        off_code = 4'hF;
        data_pin = 1'b1;
        wait_st(4, 80, took);
        data_pin = 1'b0;
        wait_st(5, 10, took);
        step(400);
        check("R8 stays in standby", state_o, 5);
        data_pin = 1'b1;
        step(3);
        check("R8 direct retransmit", state_o, 4);
        off_code = 4'd1;
        data_pin = 1'b0;
        wait_st(5, 10, took);
        wait_st(2, 200, took);
        check_rng("R7 after retransmit", took, stby_lo(1), stby_hi(1));

        // R9 clock low with data low never enters configuration
        clk_pin = 1'b0;
        step(80);
        check("R9 data low no cfg", cfg_mode, 0);
        clk_pin = 1'b1;
        wait_st(2, 200, took);

        // R9 entry: data high, clock held low
        data_pin = 1'b1;
        step(4);
        clk_pin = 1'b0;
        wait_st(6, 80, took);
        check_rng("R9 hold time", took, 2 * HOLD, 2 * HOLD + 8);
        check("R9 cfg outputs", {cfg_mode, synth_en, pa_en}, 3'b100);

        // R10 long low without stop stays
        step(60);
        check("R10 no stop stays", state_o, 6);
        clk_pin = 1'b1;
        step(5);
        stop_det = 1'b1;
        step(1);
        stop_det = 1'b0;
        step(4);
        clk_pin = 1'b0;
        wait_st(2, 80, took);
        check_rng("R10 exit hold", took, 2 * HOLD, 2 * HOLD + 8);
        check("R10 cfg_mode low", cfg_mode, 0);

        // R9 rearm: no re-entry until clock seen high
        step(60);
        check("R9 rearm needed", state_o, 2);

        // R11 idle exit
        clk_pin = 1'b1;
        data_pin = 1'b0;
        step(5);
        data_pin = 1'b1;
        step(4);
        clk_pin = 1'b0;
        wait_st(6, 80, took);
        check("R9 second entry", state_o, 6);
        wait_st(2, 300, took);
        check_rng("R11 idle exit", took, (IDLE - 1) * MS_C - 2, IDLE * MS_C + 4);

        // R3 unprogrammed fuse: straight to sleep
        do_reset(1'b0);
        check("R1 state after reset", state_o, 0);
        wait_st(2, 80, took);
        check_rng("R3 por to sleep", took, POR * CPU - 4, POR * CPU + 6);
        check("R3 no copy", copy_seen, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule